// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits beside the processor core of a microcontroller that rewrites its own paged program flash. Software first writes a command code into an 8-bit control register. A store instruction, seen here as a one-cycle strobe, must then follow within a short window. The strobe starts the chosen action. The actions are: place a data word in the temporary page buffer, erase a page, program a page, re-enable reading of the read-while-write area, or set lock bits. Each action leaves the block as a one-cycle strobe. The strobes for erase and program carry a page index that is latched when the action starts.

The block is a three-state machine. `ST_IDLE` waits for a valid command write. The transition *arm* leads from `ST_IDLE` to `ST_ARMED` on a write of an accepted code. In `ST_ARMED`, a further valid write re-arms the block (transition *rearm*), which replaces the code and restarts the window. The transition *expire* leads back to `ST_IDLE` when four cycles pass with no strobe. The transition *launch* goes to `ST_IDLE` for buffer fill, lock and re-enable, and to `ST_BUSY` for erase and program. `ST_BUSY` holds the command bits and drives the busy flag. The transition *finish* leads back to `ST_IDLE` when the flash array reports done. While the page being erased or programmed lies at or above a parameter boundary page, the core is halted.

Top module: `flash_sp_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `csr_rdata` reads 0, `busy` and `cpu_halt` are low, and no action strobe is high.
- R2: Exactly five codes are accepted in `csr_wdata[4:0]`. Bit 0 is the enable, bit 1 is erase, bit 2 is program, bit 3 is lock and bit 4 is re-enable. The accepted codes are 00001, 00011, 00101, 01001 and 10001. An accepted code reads back in `csr_rdata[4:0]` on the cycle after the write. `csr_rdata[6]` is the busy flag, and the other read bits are 0.
- R3: Writing any other 5-bit combination leaves the readback and the armed window unchanged.
- R4: A store strobe is acted on if it is sampled on any of the four clock edges that follow the write edge. If no strobe comes, the readback is 0 from the fifth edge on, and a later strobe produces nothing.
- R5: Code 00001 with a strobe pulses `buf_we` for one cycle on the cycle after the strobe. The pulse carries `buf_word = ptr[6:1]` (`ptr[0]` is ignored) and `buf_wdata = data_in`, and the register clears.
- R6: Code 00011 with a strobe pulses `erase_stb` and raises `busy`. The readback stays 0x43 until `flash_done` is sampled and is 0 on the cycle after that.
- R7: Code 00101 with a strobe pulses `write_stb` and behaves like R6, with a readback of 0x45.
- R8: `op_page` takes `ptr[15:7]` at the launch edge of an erase or program. Pointer changes after that do not move it.
- R9: Code 01001 with a strobe pulses `lock_stb` with `lock_data = data_in[7:0]`. The pointer has no effect: `op_page` is unchanged.
- R10: Code 10001 with a strobe pulses `rww_en_stb` and no other strobe.
- R11: `cpu_halt` is high for the whole busy period exactly when `op_page >= NRWW_FIRST_PAGE` (default 448). It is low otherwise.
- R12: Register writes while busy are ignored.
- R13: A store strobe while not armed, whether idle or busy, produces no action strobe.
- R14: Reset clears the latched page, so `op_page` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write enable |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register readback, busy at bit 6 |
| store_stb | input | 1 | Store instruction strobe |
| ptr | input | 16 | Address pointer |
| data_in | input | 16 | Data word for the page buffer or lock bits |
| flash_done | input | 1 | Flash array finished erase or program |
| buf_we | output | 1 | Page buffer write strobe |
| buf_word | output | 6 | Word index within the page |
| buf_wdata | output | 16 | Word to store in the page buffer |
| erase_stb | output | 1 | Page erase start strobe |
| write_stb | output | 1 | Page program start strobe |
| op_page | output | 9 | Latched page index |
| lock_stb | output | 1 | Lock-bit set strobe |
| lock_data | output | 8 | Lock bit value |
| rww_en_stb | output | 1 | Read-while-write re-enable strobe |
| busy | output | 1 | Erase or program in progress |
| cpu_halt | output | 1 | Core halt request |

## Verification
A register write is visible in `csr_rdata` one edge after it is sampled. Action strobes, `op_page`, `busy` and `cpu_halt` also change one edge after the sampled store strobe. The clearing caused by `flash_done` is seen one edge after done is sampled. The window is probed at its last valid edge, which is the fourth after the write, and at the first edge past it. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each result is sampled half a cycle after the rising edge that made it. Pulse widths are confirmed one cycle later again.

// File: rtl/flash_sp_pkg.sv
package flash_sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSY
    } sp_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FILL,
        OP_ERASE,
        OP_WRITE,
        OP_LOCK,
        OP_RWW
    } sp_op_e;

    localparam logic [4:0] CODE_FILL  = 5'b00001;
    localparam logic [4:0] CODE_ERASE = 5'b00011;
    localparam logic [4:0] CODE_WRITE = 5'b00101;
    localparam logic [4:0] CODE_LOCK  = 5'b01001;
    localparam logic [4:0] CODE_RWW   = 5'b10001;

endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
    import flash_sp_pkg::*;
(
    input  logic [4:0] code,
    output logic       valid,
    output sp_op_e     op
);
    always_comb begin
        valid = 1'b1;
        case (code)
            CODE_FILL:  op = OP_FILL;
            CODE_ERASE: op = OP_ERASE;
            CODE_WRITE: op = OP_WRITE;
            CODE_LOCK:  op = OP_LOCK;
            CODE_RWW:   op = OP_RWW;
            default: begin
                op    = OP_NONE;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sp_window_timer.sv
module sp_window_timer #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                            cnt_q <= '0;
        else if (start)                     cnt_q <= '0;
        else if (run && (cnt_q != LAST))    cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/flash_sp_ctrl.sv
module flash_sp_ctrl
    import flash_sp_pkg::*;
#(
    parameter int PTR_W           = 16,
    parameter int DATA_W          = 16,
    parameter int PAGE_WORDS      = 64,
    parameter int NRWW_FIRST_PAGE = 448,
    parameter int WINDOW          = 4,
    parameter int LOCK_W          = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   csr_we,
    input  logic [7:0]             csr_wdata,
    output logic [7:0]             csr_rdata,
    input  logic                   store_stb,
    input  logic [PTR_W-1:0]       ptr,
    input  logic [DATA_W-1:0]      data_in,
    input  logic                   flash_done,
    output logic                   buf_we,
    output logic [$clog2(PAGE_WORDS)-1:0] buf_word,
    output logic [DATA_W-1:0]      buf_wdata,
    output logic                   erase_stb,
    output logic                   write_stb,
    output logic [PTR_W-2-$clog2(PAGE_WORDS):0] op_page,
    output logic                   lock_stb,
    output logic [LOCK_W-1:0]      lock_data,
    output logic                   rww_en_stb,
    output logic                   busy,
    output logic                   cpu_halt
);
    localparam int WORD_W = $clog2(PAGE_WORDS);
    localparam int PAGE_W = PTR_W - 1 - WORD_W;
    localparam logic [PAGE_W-1:0] HALT_PAGE = PAGE_W'(NRWW_FIRST_PAGE);

    sp_state_e  state_q, state_d;
    logic [4:0] cmd_q, cmd_d;
    logic       wr_valid, held_valid_unused, win_expire, win_start, launch;
    sp_op_e     wr_op_unused, held_op;
    logic       ptr_unused;
    logic [2:0] wdata_unused;

    assign ptr_unused   = ptr[0];
    assign wdata_unused = csr_wdata[7:5];

    sp_cmd_decode u_wr_dec (
        .code (csr_wdata[4:0]),
        .valid(wr_valid),
        .op   (wr_op_unused)
    );

    sp_cmd_decode u_held_dec (
        .code (cmd_q),
        .valid(held_valid_unused),
        .op   (held_op)
    );

    assign launch    = (state_q == ST_ARMED) && store_stb;
    assign win_start = csr_we && wr_valid && !launch && (state_q != ST_BUSY);

    sp_window_timer #(.WINDOW(WINDOW)) u_win (
        .clk   (clk),
        .rst   (rst),
        .start (win_start),
        .run   (state_q == ST_ARMED),
        .expire(win_expire)
    );

    // next-state: arm, rearm, expire, launch, finish
    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (csr_we && wr_valid) begin
                    state_d = ST_ARMED;
                    cmd_d   = csr_wdata[4:0];
                end
            end
            ST_ARMED: begin
                if (store_stb) begin
                    if (held_op == OP_ERASE || held_op == OP_WRITE) begin
                        state_d = ST_BUSY;
                    end else begin
                        state_d = ST_IDLE;
                        cmd_d   = '0;
                    end
                end else if (csr_we && wr_valid) begin
                    cmd_d = csr_wdata[4:0];
                end else if (win_expire) begin
                    state_d = ST_IDLE;
                    cmd_d   = '0;
                end
            end
            ST_BUSY: begin
                if (flash_done) begin
                    state_d = ST_IDLE;
                    cmd_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cmd_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_we     <= 1'b0;
            buf_word   <= '0;
            buf_wdata  <= '0;
            erase_stb  <= 1'b0;
            write_stb  <= 1'b0;
            op_page    <= '0;
            lock_stb   <= 1'b0;
            lock_data  <= '0;
            rww_en_stb <= 1'b0;
        end else begin
            buf_we     <= 1'b0;
            erase_stb  <= 1'b0;
            write_stb  <= 1'b0;
            lock_stb   <= 1'b0;
            rww_en_stb <= 1'b0;
            if (launch) begin
                unique case (held_op)
                    OP_FILL: begin
                        buf_we    <= 1'b1;
                        buf_word  <= ptr[WORD_W:1];
                        buf_wdata <= data_in;
                    end
                    OP_ERASE: begin
                        erase_stb <= 1'b1;
                        op_page   <= ptr[PTR_W-1 -: PAGE_W];
                    end
                    OP_WRITE: begin
                        write_stb <= 1'b1;
                        op_page   <= ptr[PTR_W-1 -: PAGE_W];
                    end
                    OP_LOCK: begin
                        lock_stb  <= 1'b1;
                        lock_data <= data_in[LOCK_W-1:0];
                    end
                    OP_RWW:  rww_en_stb <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign busy      = (state_q == ST_BUSY);
    assign cpu_halt  = busy && (op_page >= HALT_PAGE);
    assign csr_rdata = {1'b0, busy, 1'b0, cmd_q};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({buf_we, erase_stb, write_stb, lock_stb, rww_en_stb})); // R10
    AST_NO_STROBE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (store_stb && state_q != ST_ARMED) |=>
        !(buf_we || erase_stb || write_stb || lock_stb || rww_en_stb)); // R13
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_page)); // R8
    AST_HALT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cpu_halt)); // R11
    AST_BUSY_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !flash_done) |=> csr_rdata[0]); // R6
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && csr_we && !flash_done) |=> $stable(csr_rdata[4:0])); // R12
    AST_LOCK_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
        lock_stb |-> $stable(op_page)); // R9
endmodule

// File: tb/test_flash_sp_ctrl.sv
module test_flash_sp_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        store_stb = 1'b0;
    logic [15:0] ptr = '0;
    logic [15:0] data_in = '0;
    logic        flash_done = 1'b0;
    logic        buf_we, erase_stb, write_stb, lock_stb, rww_en_stb, busy, cpu_halt;
    logic [5:0]  buf_word;
    logic [15:0] buf_wdata;
    logic [8:0]  op_page;
    logic [7:0]  lock_data;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_sp_ctrl i_flash_sp_ctrl (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .store_stb(store_stb), .ptr(ptr),
        .data_in(data_in), .flash_done(flash_done), .buf_we(buf_we),
        .buf_word(buf_word), .buf_wdata(buf_wdata), .erase_stb(erase_stb),
        .write_stb(write_stb), .op_page(op_page), .lock_stb(lock_stb),
        .lock_data(lock_data), .rww_en_stb(rww_en_stb), .busy(busy),
        .cpu_halt(cpu_halt)
    );

    function automatic logic [4:0] strobes();
        return {rww_en_stb, lock_stb, write_stb, erase_stb, buf_we};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        csr_we = 1'b1; csr_wdata = v; step(); csr_we = 1'b0;
    endtask

    task automatic stb(input logic [15:0] p, input logic [15:0] d);
        store_stb = 1'b1; ptr = p; data_in = d; step(); store_stb = 1'b0;
    endtask

    task automatic done_pulse();
        flash_done = 1'b1; step(); flash_done = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; step();
        chk("R1 rdata", csr_rdata, 0);
        chk("R1 strobes", strobes(), 0);
        chk("R1 busy/halt", {busy, cpu_halt}, 0);
        chk("R14 page", op_page, 0);
    endtask

    task automatic t_codes();
        logic [4:0] codes [5] = '{5'h01, 5'h03, 5'h05, 5'h09, 5'h11};
        foreach (codes[i]) begin
            wr({3'b0, codes[i]});
            chk("R2 readback", csr_rdata, {3'b0, codes[i]});
            repeat (4) step();
            chk("R4 expired", csr_rdata, 0);
        end
    endtask

    task automatic t_invalid();
        wr(8'h06);
        chk("R3 idle invalid", csr_rdata, 0);
        wr(8'h01);
        wr(8'h07);
        chk("R3 armed invalid", csr_rdata, 8'h01);
        wr(8'h1F);
        chk("R3 armed invalid 2", csr_rdata, 8'h01);
        repeat (3) step();
        chk("R3 window not restarted", csr_rdata, 0);
    endtask

    task automatic t_window();
        wr(8'h01);
        repeat (3) step();
        stb(16'h0002, 16'h1111);
        chk("R4 last edge accepted", buf_we, 1);
        chk("R4 word", buf_word, 1);
        wr(8'h01);
        repeat (4) step();
        stb(16'h0002, 16'h2222);
        chk("R4 late strobe", strobes(), 0);
        chk("R4 late rdata", csr_rdata, 0);
    endtask

    task automatic t_fill();
        wr(8'h01);
        stb(16'h1235, 16'hBEEF);
        chk("R5 we", strobes(), 5'b00001);
        chk("R5 word", buf_word, 6'h1A);
        chk("R5 data", buf_wdata, 16'hBEEF);
        chk("R5 cleared", csr_rdata, 0);
        step();
        chk("R5 one cycle", buf_we, 0);
    endtask

    task automatic t_erase();
        wr(8'h03);
        stb(16'hABCD, 16'h0);
        chk("R6 erase stb", strobes(), 5'b00010);
        chk("R8 page", op_page, 9'h157);
        chk("R6 busy rdata", csr_rdata, 8'h43);
        chk("R11 no halt", cpu_halt, 0);
        ptr = 16'hFFFF; step();
        chk("R8 page held", op_page, 9'h157);
        chk("R6 pulse", erase_stb, 0);
        wr(8'h01);
        chk("R12 write ignored", csr_rdata, 8'h43);
        stb(16'h0000, 16'h0);
        chk("R13 busy strobe", strobes(), 0);
        repeat (3) step();
        chk("R6 still busy", busy, 1);
        done_pulse();
        chk("R6 finished", csr_rdata, 0);
        chk("R12 not armed", csr_rdata, 0);
    endtask

    task automatic t_write();
        wr(8'h05);
        stb(16'hF0FF, 16'h0);
        chk("R7 write stb", strobes(), 5'b00100);
        chk("R7 page", op_page, 9'h1E1);
        chk("R7 rdata", csr_rdata, 8'h45);
        chk("R11 halt", cpu_halt, 1);
        step();
        chk("R11 halt held", cpu_halt, 1);
        done_pulse();
        chk("R11 halt end", cpu_halt, 0);
        chk("R7 finished", csr_rdata, 0);
    endtask

    task automatic t_halt_edge();
        wr(8'h03);
        stb(16'hDF80, 16'h0);
        chk("R11 page 447", {op_page, cpu_halt}, {9'd447, 1'b0});
        done_pulse();
        wr(8'h03);
        stb(16'hE000, 16'h0);
        chk("R11 page 448", {op_page, cpu_halt}, {9'd448, 1'b1});
        done_pulse();
    endtask

    task automatic t_lock_rww();
        wr(8'h09);
        stb(16'h1234, 16'h00A5);
        chk("R9 lock stb", strobes(), 5'b01000);
        chk("R9 data", lock_data, 8'hA5);
        chk("R9 page untouched", op_page, 9'd448);
        chk("R9 cleared", csr_rdata, 0);
        wr(8'h11);
        stb(16'h0000, 16'h0);
        chk("R10 rww stb", strobes(), 5'b10000);
        step();
        chk("R10 pulse", strobes(), 0);
    endtask

    task automatic t_unarmed();
        stb(16'h1234, 16'h5678);
        chk("R13 idle strobe", strobes(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_codes();
        t_invalid();
        t_window();
        t_fill();
        t_erase();
        t_write();
        t_halt_edge();
        t_lock_rww();
        t_unarmed();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule